// File: doc/BRIEF.md
# Configuration Descriptor Piece Walker

This block takes a vendor configuration descriptor one byte per handshake and parses it as it arrives. It first checks a five-byte header:

- the overall length;
- a tag byte;
- a 16-bit version;
- an inner data length that must agree with the overall length.

After the header it walks a chain of pieces. Each piece has a 16-bit little-endian type, an 8-bit length and that many data bytes. For every piece it emits a header event and then one event per data byte, so a downstream agent can interpret any piece type it cares about.

A few well-known pieces are also decoded in place. The maximum width, maximum height and maximum area are held in parameter registers. Five per-mode enable bits are held alongside them.

Byte 0 of each descriptor sets how many bytes that descriptor occupies. After a descriptor ends (cleanly or with an error), the next accepted byte is taken as the first byte of a new descriptor. Every output is registered and appears on the clock edge that accepts the byte causing it.

Top module: `vdesc_parser`

## Requirements
- R1: While `rst` is high, and on the first edge after it falls, `in_ready` is low. From then on it stays high. Reset clears every event output, `max_width`, `max_height`, `max_area` and `mode_en` to zero.
- R2: A descriptor of overall length 5 with tag 0x5F, version bytes 0x01 then 0x00, and data length 3 produces a single `done` pulse, and no other event, on the edge that accepts its fifth byte.
- R3: If the second byte is not 0x5F, `err` pulses once on that byte's edge. The remaining bytes of that descriptor produce no event. The byte that follows them is parsed as a new descriptor.
- R4: The version is read with byte 2 as the low byte and byte 3 as the high byte. A version other than 0x0001 gives one `err` pulse and drops the rest of the descriptor.
- R5: If byte 4 differs from byte 0 minus 2, one `err` pulse results. If byte 4 is also the last byte of the descriptor, parsing restarts with the next byte.
- R6: An overall length below 5 gives one `err` pulse on byte 0. Lengths 0 and 1 occupy only that byte. Lengths 2 to 4 occupy that many bytes in total.
- R7: Each piece produces a `pc_valid` pulse on the edge that accepts its length byte. `pc_type` equals first byte + 256 × second byte, and `pc_len` equals the third byte.
- R8: Each data byte of a piece gives a `pd_valid` pulse carrying the byte in `pd_data`. `pd_last` is high only on the final byte. A zero-length piece gives only its `pc_valid` pulse. A piece whose data ends exactly at the descriptor end is accepted.
- R9: A piece length greater than the number of descriptor bytes left after the length byte gives one `err` pulse. It gives no `pc_valid`, no data events and no `done`, and the rest of the descriptor is dropped.
- R10: A descriptor that ends after only one or two bytes of a piece header gives an `err` pulse on its last byte instead of `done`.
- R11: Pieces of type 0x0201, 0x0202 and 0x0200 with length 4 load `max_width`, `max_height` and `max_area` respectively, as little-endian 32-bit values, one cycle after the last data byte. Those types with any other length leave the registers unchanged.
- R12: A piece of type 0x0001 + i (i from 0 to 4) with length 1 sets `mode_en[i]` to 1 if its byte is nonzero and to 0 otherwise. The update lands one cycle after the byte. Any other type or length leaves `mode_en` unchanged.
- R13: `done` pulses on the edge of the final byte only when the descriptor had no error. `done` and `err` never pulse together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Byte offered |
| in_data | input | 8 | Offered byte |
| in_ready | output | 1 | Byte accepted when high with in_valid |
| pc_valid | output | 1 | Piece header event |
| pc_type | output | 16 | Piece type |
| pc_len | output | 8 | Piece data length |
| pd_valid | output | 1 | Piece data byte event |
| pd_data | output | 8 | Piece data byte |
| pd_last | output | 1 | Final data byte of the piece |
| done | output | 1 | Descriptor parsed cleanly |
| err | output | 1 | Descriptor error detected |
| max_width | output | PARAM_W | Captured maximum width |
| max_height | output | PARAM_W | Captured maximum height |
| max_area | output | PARAM_W | Captured maximum area |
| mode_en | output | NUM_MODES | Captured mode enables |

## Verification
The properties assume that bytes enter only through the handshake, so at most one event of any kind can follow each accepted byte. They also assume that the data events of a piece follow its header event, with no new header in between. The stimulus keeps within this by driving the bytes of whole descriptors back to back, including malformed ones, with idle gaps placed among them. Each malformed descriptor is still padded to the length that its byte 0 declares, so every descriptor boundary matches what the block counts.

// File: rtl/vdesc_pkg.sv
package vdesc_pkg;
  localparam logic [7:0]  DESC_TAG    = 8'h5F;
  localparam logic [15:0] DESC_VER    = 16'h0001;
  localparam logic [15:0] T_AREA      = 16'h0200;
  localparam logic [15:0] T_WIDTH     = 16'h0201;
  localparam logic [15:0] T_HEIGHT    = 16'h0202;
  localparam logic [15:0] T_MODE_BASE = 16'h0001;
  localparam logic [7:0]  HDR_BYTES   = 8'd5;

  typedef enum logic [3:0] {
    S_LEN, S_TAG, S_VER_LO, S_VER_HI, S_DLEN,
    S_PT_LO, S_PT_HI, S_PLEN, S_PDATA, S_DROP
  } walk_st_t;
endpackage

// File: rtl/vdesc_byte_cnt.sv
module vdesc_byte_cnt #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          step,
  output logic [CW-1:0] rem,
  output logic          is_last
);
  logic [CW-1:0] rem_q;

  always_ff @(posedge clk) begin
    if (rst)                 rem_q <= '0;
    else if (load)           rem_q <= load_val;
    else if (step && rem_q != '0) rem_q <= rem_q - 1'b1;
  end

  assign rem     = rem_q;
  assign is_last = (rem_q == CW'(1));
endmodule

// File: rtl/vdesc_walker.sv
module vdesc_walker
  import vdesc_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        acc,
  input  logic [7:0]  in_byte,
  input  logic [7:0]  rem,
  input  logic        is_last,
  output logic        cnt_load,
  output logic [7:0]  cnt_val,
  output logic        cnt_step,
  output logic        pc_valid,
  output logic [15:0] cur_type,
  output logic [7:0]  cur_len,
  output logic        pd_valid,
  output logic [7:0]  pd_data,
  output logic        pd_last,
  output logic        done,
  output logic        err
);
  walk_st_t   st_q;
  logic [7:0] tot_q;
  logic [7:0] dcnt_q;
  logic [15:0] ver_lo_q;

  assign cnt_load = acc && (st_q == S_LEN);
  assign cnt_val  = (in_byte == 8'd0) ? 8'd0 : in_byte - 8'd1;
  assign cnt_step = acc && (st_q != S_LEN);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= S_LEN;
      tot_q    <= '0;
      dcnt_q   <= '0;
      ver_lo_q <= '0;
      cur_type <= '0;
      cur_len  <= '0;
      pc_valid <= 1'b0;
      pd_valid <= 1'b0;
      pd_data  <= '0;
      pd_last  <= 1'b0;
      done     <= 1'b0;
      err      <= 1'b0;
    end else begin
      pc_valid <= 1'b0;
      pd_valid <= 1'b0;
      pd_last  <= 1'b0;
      done     <= 1'b0;
      err      <= 1'b0;
      if (acc) begin
        case (st_q)
          S_LEN: begin
            tot_q <= in_byte;
            if (in_byte < HDR_BYTES) begin
              err  <= 1'b1;
              st_q <= (in_byte <= 8'd1) ? S_LEN : S_DROP;
            end else begin
              st_q <= S_TAG;
            end
          end
          S_TAG: begin
            if (in_byte != DESC_TAG) begin
              err  <= 1'b1;
              st_q <= S_DROP;
            end else st_q <= S_VER_LO;
          end
          S_VER_LO: begin
            ver_lo_q <= {8'd0, in_byte};
            st_q     <= S_VER_HI;
          end
          S_VER_HI: begin
            if ({in_byte, ver_lo_q[7:0]} != DESC_VER) begin
              err  <= 1'b1;
              st_q <= S_DROP;
            end else st_q <= S_DLEN;
          end
          S_DLEN: begin
            if (in_byte != tot_q - 8'd2) begin
              err  <= 1'b1;
              st_q <= is_last ? S_LEN : S_DROP;
            end else if (is_last) begin
              done <= 1'b1;
              st_q <= S_LEN;
            end else st_q <= S_PT_LO;
          end
          S_PT_LO: begin
            cur_type[7:0] <= in_byte;
            if (is_last) begin
              err  <= 1'b1;
              st_q <= S_LEN;
            end else st_q <= S_PT_HI;
          end
          S_PT_HI: begin
            cur_type[15:8] <= in_byte;
            if (is_last) begin
              err  <= 1'b1;
              st_q <= S_LEN;
            end else st_q <= S_PLEN;
          end
          S_PLEN: begin
            if (in_byte > rem - 8'd1) begin
              err  <= 1'b1;
              st_q <= is_last ? S_LEN : S_DROP;
            end else begin
              cur_len  <= in_byte;
              dcnt_q   <= in_byte;
              pc_valid <= 1'b1;
              if (in_byte == 8'd0) begin
                if (is_last) begin
                  done <= 1'b1;
                  st_q <= S_LEN;
                end else st_q <= S_PT_LO;
              end else st_q <= S_PDATA;
            end
          end
          S_PDATA: begin
            pd_valid <= 1'b1;
            pd_data  <= in_byte;
            pd_last  <= (dcnt_q == 8'd1);
            dcnt_q   <= dcnt_q - 8'd1;
            if (dcnt_q == 8'd1) begin
              if (is_last) begin
                done <= 1'b1;
                st_q <= S_LEN;
              end else st_q <= S_PT_LO;
            end
          end
          S_DROP: begin
            if (is_last) st_q <= S_LEN;
          end
          default: st_q <= S_LEN;
        endcase
      end
    end
  end
endmodule

// File: rtl/vdesc_param_cap.sv
module vdesc_param_cap
  import vdesc_pkg::*;
#(
  parameter int PARAM_W   = 32,
  parameter int NUM_MODES = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 pd_valid,
  input  logic [7:0]           pd_data,
  input  logic                 pd_last,
  input  logic [15:0]          piece_type,
  input  logic [7:0]           piece_len,
  output logic [PARAM_W-1:0]   max_width,
  output logic [PARAM_W-1:0]   max_height,
  output logic [PARAM_W-1:0]   max_area,
  output logic [NUM_MODES-1:0] mode_en
);
  localparam int PB = PARAM_W / 8;

  logic [PARAM_W-1:0] sh_q;
  logic [PARAM_W-1:0] word;
  logic               word_end;

  assign word     = {pd_data, sh_q[PARAM_W-1:8]};
  assign word_end = pd_valid && pd_last && (piece_len == 8'(PB));

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q       <= '0;
      max_width  <= '0;
      max_height <= '0;
      max_area   <= '0;
    end else if (pd_valid) begin
      sh_q <= word;
      if (word_end) begin
        if (piece_type == T_WIDTH)  max_width  <= word;
        if (piece_type == T_HEIGHT) max_height <= word;
        if (piece_type == T_AREA)   max_area   <= word;
      end
    end
  end

  for (genvar i = 0; i < NUM_MODES; i++) begin : g_mode
    logic bit_q;
    always_ff @(posedge clk) begin
      if (rst) bit_q <= 1'b0;
      else if (pd_valid && pd_last && piece_len == 8'd1 &&
               piece_type == T_MODE_BASE + 16'(i))
        bit_q <= (pd_data != 8'd0);
    end
    assign mode_en[i] = bit_q;
  end
endmodule

// File: rtl/vdesc_parser.sv
module vdesc_parser #(
  parameter int PARAM_W   = 32,
  parameter int NUM_MODES = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [7:0]           in_data,
  output logic                 in_ready,
  output logic                 pc_valid,
  output logic [15:0]          pc_type,
  output logic [7:0]           pc_len,
  output logic                 pd_valid,
  output logic [7:0]           pd_data,
  output logic                 pd_last,
  output logic                 done,
  output logic                 err,
  output logic [PARAM_W-1:0]   max_width,
  output logic [PARAM_W-1:0]   max_height,
  output logic [PARAM_W-1:0]   max_area,
  output logic [NUM_MODES-1:0] mode_en
);
  logic       ready_q;
  logic       acc;
  logic       cnt_load, cnt_step, is_last;
  logic [7:0] cnt_val, rem;

  always_ff @(posedge clk) begin
    if (rst) ready_q <= 1'b0;
    else     ready_q <= 1'b1;
  end
  assign in_ready = ready_q;
  assign acc      = in_valid && ready_q;

  vdesc_byte_cnt #(.CW(8)) u_cnt (
    .clk(clk), .rst(rst), .load(cnt_load), .load_val(cnt_val),
    .step(cnt_step), .rem(rem), .is_last(is_last)
  );

  vdesc_walker u_walk (
    .clk(clk), .rst(rst), .acc(acc), .in_byte(in_data),
    .rem(rem), .is_last(is_last),
    .cnt_load(cnt_load), .cnt_val(cnt_val), .cnt_step(cnt_step),
    .pc_valid(pc_valid), .cur_type(pc_type), .cur_len(pc_len),
    .pd_valid(pd_valid), .pd_data(pd_data), .pd_last(pd_last),
    .done(done), .err(err)
  );

  vdesc_param_cap #(.PARAM_W(PARAM_W), .NUM_MODES(NUM_MODES)) u_cap (
    .clk(clk), .rst(rst), .pd_valid(pd_valid), .pd_data(pd_data),
    .pd_last(pd_last), .piece_type(pc_type), .piece_len(pc_len),
    .max_width(max_width), .max_height(max_height),
    .max_area(max_area), .mode_en(mode_en)
  );
endmodule

// File: rtl/vdesc_parser_chk.sv
module vdesc_parser_chk (
  input logic       clk,
  input logic       rst,
  input logic       in_valid,
  input logic       in_ready,
  input logic       pc_valid,
  input logic [7:0] pc_len,
  input logic       pd_valid,
  input logic       pd_last,
  input logic       done,
  input logic       err
);
  logic [7:0] left_q;

  always_ff @(posedge clk) begin
    if (rst) left_q <= '0;
    else if (pc_valid) left_q <= pc_len;
    else if (pd_valid && left_q != 8'd0) left_q <= left_q - 8'd1;
  end

  // R13: a clean finish and an error never coincide
  assert_done_err_excl_R13: assert property (@(posedge clk) disable iff (rst)
    !(done && err));

  // R7/R8: each event follows an accepted byte
  assert_event_needs_byte_R7: assert property (@(posedge clk) disable iff (rst)
    (pc_valid || pd_valid || done || err) |-> $past(in_valid && in_ready));

  // R8: header and data events never share a cycle
  assert_pc_pd_excl_R8: assert property (@(posedge clk) disable iff (rst)
    !(pc_valid && pd_valid));

  // R8: data bytes only within a declared piece
  assert_data_in_piece_R8: assert property (@(posedge clk) disable iff (rst)
    pd_valid |-> left_q != 8'd0);

  // R8: last flag marks exactly the final declared byte
  assert_last_marks_end_R8: assert property (@(posedge clk) disable iff (rst)
    pd_valid |-> (pd_last == (left_q == 8'd1)));

  // R7: a new piece header only after the previous data completed
  assert_header_after_data_R7: assert property (@(posedge clk) disable iff (rst)
    pc_valid |-> left_q == 8'd0);

  // R8: last flag never without a data byte
  assert_last_has_data_R8: assert property (@(posedge clk) disable iff (rst)
    pd_last |-> pd_valid);
endmodule

bind vdesc_parser vdesc_parser_chk u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .pc_valid(pc_valid), .pc_len(pc_len), .pd_valid(pd_valid),
  .pd_last(pd_last), .done(done), .err(err)
);

// File: tb/vdesc_parser_tb.sv
module vdesc_parser_tb;
  localparam int EV_PC = 0, EV_PD = 1, EV_DONE = 2, EV_ERR = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = 8'd0;
  logic        in_ready, pc_valid, pd_valid, pd_last, done, err;
  logic [15:0] pc_type;
  logic [7:0]  pc_len, pd_data;
  logic [31:0] max_width, max_height, max_area;
  logic [4:0]  mode_en;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  logic [7:0]  bq[$];
  int          ek[$];
  logic [23:0] ev[$];
  string       et[$];

  always #10 clk = ~clk;

  vdesc_parser u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .pc_valid(pc_valid), .pc_type(pc_type),
    .pc_len(pc_len), .pd_valid(pd_valid), .pd_data(pd_data),
    .pd_last(pd_last), .done(done), .err(err), .max_width(max_width),
    .max_height(max_height), .max_area(max_area), .mode_en(mode_en)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic expect_ev(input int k, input logic [23:0] v, input string tag);
    ek.push_back(k); ev.push_back(v); et.push_back(tag);
  endtask

  task automatic observe(input int k, input logic [23:0] v);
    if (ek.size() == 0) begin
      check(1'b0, $sformatf("unexpected event kind %0d", k), {8'd0, v}, 32'd0);
    end else begin
      int          xk = ek.pop_front();
      logic [23:0] xv = ev.pop_front();
      string       xt = et.pop_front();
      check(xk == k && xv == v, xt, {k[7:0], v}, {xk[7:0], xv});
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (pc_valid) observe(EV_PC, {pc_type, pc_len});
      if (pd_valid) observe(EV_PD, {15'd0, pd_last, pd_data});
      if (done)     observe(EV_DONE, 24'd0);
      if (err)      observe(EV_ERR, 24'd0);
    end
  end

  task automatic put(input logic [7:0] b);
    bq.push_back(b);
  endtask

  task automatic hdr(input logic [7:0] total);
    put(total); put(8'h5F); put(8'h01); put(8'h00); put(total - 8'd2);
  endtask

  task automatic piece(input logic [15:0] t, input logic [7:0] n,
                       input logic [31:0] d, input string tag);
    put(t[7:0]); put(t[15:8]); put(n);
    expect_ev(EV_PC, {t, n}, tag);
    for (int i = 0; i < int'(n); i++) begin
      put(d[8*i +: 8]);
      expect_ev(EV_PD, {15'd0, (i == int'(n) - 1), d[8*i +: 8]}, tag);
    end
  endtask

  task automatic send_all();
    int gap = 0;
    while (bq.size() > 0) begin
      @(negedge clk);
      gap++;
      if (gap % 4 == 3) begin
        in_valid = 1'b0;
      end else begin
        in_valid = 1'b1;
        in_data  = bq.pop_front();
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    while (cyc < 20000) @(posedge clk);
    check(1'b0, "watchdog expired", cyc, 32'd20000);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(in_ready == 1'b0, "R1 in_ready in reset", in_ready, 0);
    check({pc_valid, pd_valid, done, err} == 4'd0, "R1 events in reset",
          {pc_valid, pd_valid, done, err}, 0);
    check(max_width == 0 && max_height == 0 && max_area == 0 && mode_en == 0,
          "R1 params in reset", max_width | max_height | max_area | mode_en, 0);
    rst = 1'b0;
    @(negedge clk);
    check(in_ready == 1'b1, "R1 in_ready after reset", in_ready, 1);

    // R2: empty descriptor
    hdr(8'd5); expect_ev(EV_DONE, 0, "R2 empty done");
    // R3: bad tag, then recovery
    put(8'h08); put(8'h5E); repeat (6) put(8'h00);
    expect_ev(EV_ERR, 0, "R3 bad tag");
    hdr(8'd5); expect_ev(EV_DONE, 0, "R3 resume after drop");
    // R4: bad version low, bad version high
    put(8'h07); put(8'h5F); put(8'h02); put(8'h00); put(8'h05); put(8'hAA); put(8'hBB);
    expect_ev(EV_ERR, 0, "R4 version low byte");
    put(8'h07); put(8'h5F); put(8'h01); put(8'h01); put(8'h05); put(8'h01); put(8'h02);
    expect_ev(EV_ERR, 0, "R4 version high byte");
    // R5: data length mismatch, mid and at the end
    put(8'h06); put(8'h5F); put(8'h01); put(8'h00); put(8'h07); put(8'h00);
    expect_ev(EV_ERR, 0, "R5 dlen mismatch");
    put(8'h05); put(8'h5F); put(8'h01); put(8'h00); put(8'h02);
    expect_ev(EV_ERR, 0, "R5 dlen mismatch on last byte");
    // R6: short lengths
    put(8'h03); put(8'h5F); put(8'h01); expect_ev(EV_ERR, 0, "R6 length 3");
    put(8'h00); expect_ev(EV_ERR, 0, "R6 length 0");
    put(8'h01); expect_ev(EV_ERR, 0, "R6 length 1");
    hdr(8'd5); expect_ev(EV_DONE, 0, "R6 resume");
    send_all();

    // R7 R8 R11 R12: full descriptor
    hdr(8'd42);
    piece(16'h0201, 8'd4, 32'h0000_0780, "R7 R11 width piece");
    piece(16'h0202, 8'd4, 32'h0000_0438, "R7 R11 height piece");
    piece(16'h0200, 8'd4, 32'h001F_A000, "R7 R11 area piece");
    piece(16'h0001, 8'd1, 32'h07, "R12 mode0 piece");
    piece(16'h0005, 8'd1, 32'h01, "R12 mode4 piece");
    piece(16'h0400, 8'd2, 32'hBBAA, "R8 unknown piece");
    piece(16'h0600, 8'd0, 32'h0, "R8 zero-length piece");
    expect_ev(EV_DONE, 0, "R13 done after full descriptor");
    send_all();
    repeat (3) @(negedge clk);
    check(max_width == 32'd1920, "R11 max_width", max_width, 1920);
    check(max_height == 32'd1080, "R11 max_height", max_height, 1080);
    check(max_area == 32'h001F_A000, "R11 max_area", max_area, 32'h001FA000);
    check(mode_en == 5'b10001, "R12 mode_en set", mode_en, 5'b10001);

    // R8: data ends exactly at descriptor end; mode type with length 2 ignored
    hdr(8'd10);
    piece(16'h0003, 8'd2, 32'hBBAA, "R8 exact fit piece");
    expect_ev(EV_DONE, 0, "R8 exact fit done");
    // R11 R12: clear mode0, width with wrong length ignored
    hdr(8'd18);
    piece(16'h0001, 8'd1, 32'h00, "R12 mode0 clear");
    piece(16'h0201, 8'd2, 32'h2211, "R11 short width");
    piece(16'h0300, 8'd1, 32'h55, "R12 unknown type");
    expect_ev(EV_DONE, 0, "R13 done second");
    send_all();
    repeat (3) @(negedge clk);
    check(max_width == 32'd1920, "R11 width unchanged by short piece", max_width, 1920);
    check(mode_en == 5'b10000, "R12 mode_en after clear", mode_en, 5'b10000);

    // R9: overrun
    hdr(8'd10); put(8'h01); put(8'h02); put(8'h05); put(8'h11); put(8'h22);
    expect_ev(EV_ERR, 0, "R9 piece overruns descriptor");
    hdr(8'd5); expect_ev(EV_DONE, 0, "R9 resume");
    // R10: truncated piece headers
    hdr(8'd7); put(8'h01); put(8'h00);
    expect_ev(EV_ERR, 0, "R10 truncated after type");
    hdr(8'd6); put(8'h01);
    expect_ev(EV_ERR, 0, "R10 truncated after type low");
    hdr(8'd5); expect_ev(EV_DONE, 0, "R13 final clean");
    send_all();
    repeat (4) @(negedge clk);
    check(ek.size() == 0, "R13 all expected events seen", ek.size(), 0);
    check(mode_en == 5'b10000, "R12 mode_en untouched by errors", mode_en, 5'b10000);
    summary();
  end
endmodule